// File: doc/BRIEF.md
# Block Copy and Compare Sequencer

This block carries out the repeating memory instructions of an 8-bit processor core. The decode stage hands it one opcode byte together with the accumulator, the byte counter pair, the source pointer (HL) and the destination pointer (DE). It then runs the transfer on its own. It moves bytes from memory to memory, or scans memory for a byte equal to the accumulator. When port support is on, it also moves bytes between memory and the I/O space. At the end it hands back the stepped pointers, the counter and the status flags.

Every element uses a simple request/ready byte port toward memory and a second one toward I/O. A request is held, unchanged, until the target signals ready on a rising edge. Two opcode bits choose the mode. One picks whether the pointers step upward or downward. The other picks a single element or a loop that runs until the counter is exhausted. A repeating compare also leaves the loop early when it finds a match.

Top module: `blkmove_seq`

## Requirements
- R1: A start is accepted only while idle and only when opcode bits [7:5] equal 101 and bit 2 is 0. With PORT_EN cleared, opcodes whose bit 1 is set are also refused. A refused start leaves busy low and makes no memory or I/O request.
- R2: Opcode bits [1:0] select the operation: 00 copy, 01 compare, 10 port input, 11 port output. Each copy element reads the byte at HL and writes it to the address in DE.
- R3: Opcode bit 3 set makes HL (and DE for copy) step down by one per element. Bit 3 clear makes them step up by one. DE stays unchanged for compare and for the port forms.
- R4: A compare element reads the byte at HL and never writes. It sets Z when A equals the byte, and sets H when the low nibble of A is below the low nibble of the byte. It sets N.
- R5: A copy clears H and N, and passes the Z input through to the Z output unchanged.
- R6: Copy and compare decrement all 16 bits of BC per element. The port forms decrement only B (bits 15:8) and leave C unchanged. P/V equals "counter nonzero after the decrement". For the port forms, Z is set when B reaches zero, N is set and H is cleared.
- R7: With opcode bit 4 clear, exactly one element is processed. With bit 4 set, elements repeat until the counter reaches zero. A repeating compare also stops right after the element that matched.
- R8: A counter of zero on entry is decremented before it is tested. It therefore wraps: 65536 elements for copy and compare, 256 for the port forms.
- R9: Each access keeps its request, address, write enable and write data stable until ready is sampled high at a rising edge. The sequencer does not advance while ready is low.
- R10: The port forms put the whole BC pair on the 16-bit I/O address. Input stores the port byte at HL. Output sends the byte at HL to the port.
- R11: busy is high from the cycle after an accepted start until the run ends. done is a one-cycle pulse that coincides with the final register and flag values. A start raised while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch request, sampled while idle |
| opcode | input | 8 | Block opcode byte following the extended prefix |
| acc_i | input | DATA_W | Accumulator value |
| bc_i | input | 2*DATA_W | Counter pair on entry |
| de_i | input | 2*DATA_W | Destination pointer on entry |
| hl_i | input | 2*DATA_W | Source pointer on entry |
| zf_i | input | 1 | Incoming Z flag, kept by copy |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| bc_o | output | 2*DATA_W | Updated counter pair |
| de_o | output | 2*DATA_W | Updated destination pointer |
| hl_o | output | 2*DATA_W | Updated source pointer |
| flag_pv | output | 1 | Counter-still-nonzero flag |
| flag_z | output | 1 | Zero/match flag |
| flag_h | output | 1 | Half-borrow flag |
| flag_n | output | 1 | Subtract flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 2*DATA_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory access completes this edge |
| io_req | output | 1 | I/O access request |
| io_we | output | 1 | I/O write enable |
| io_addr | output | 2*DATA_W | I/O address (whole BC) |
| io_wdata | output | DATA_W | I/O write data |
| io_rdata | input | DATA_W | I/O read data, valid with ready |
| io_ready | input | 1 | I/O access completes this edge |

## Verification
A repeating compare has two reasons to stop: the counter reaching zero and a byte matching A. Both can occur on the same element. The bench provokes this by placing the matching byte at the last position of a scan. It then expects a single stop with Z set and P/V cleared, and a counter of zero. A second case puts the match on the first element with a zero counter on entry. There the wrap and the early stop meet, and the expected result is a counter of all ones with P/V set. Random runs with random ready stalls mix the two stop reasons with every direction and mode, and are judged against a bench model of the loop.

// File: rtl/blkseq_pkg.sv
// Package: shared types of the block copy/compare sequencer.
// Assumes: opcode field positions are fixed by the instruction encoding.
package blkseq_pkg;

    // Operation chosen by opcode bits [1:0].
    typedef enum logic [1:0] {
        K_COPY = 2'b00,
        K_CMP  = 2'b01,
        K_PIN  = 2'b10,
        K_POUT = 2'b11
    } kind_t;

    // Decoded opcode.
    typedef struct packed {
        logic  valid;
        logic  rep;
        logic  dec;
        kind_t kind;
    } blk_op_t;

    // Sequencer states.
    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_RD   = 2'b01,
        S_WR   = 2'b10,
        S_UPD  = 2'b11
    } seq_state_t;

endpackage

// File: rtl/blkseq_decode.sv
// Module: blkseq_decode
// Turns the opcode byte into a block operation descriptor.
// Assumes: pattern 101 in bits [7:5] and 0 in bit 2 marks a block opcode;
// PORT_EN = 0 removes the two port forms from the accepted set.
module blkseq_decode
    import blkseq_pkg::*;
#(
    parameter bit PORT_EN = 1'b1
) (
    input  logic [7:0] opcode,
    output blk_op_t    op
);

    logic pattern_ok;
    logic kind_ok;

    // Fixed bits that every block opcode carries.
    assign pattern_ok = (opcode[7:5] == 3'b101) && !opcode[2];

    // The build variant decides whether port forms are accepted.
    generate
        if (PORT_EN) begin : g_ports
            assign kind_ok = 1'b1;
        end else begin : g_noports
            assign kind_ok = !opcode[1];
        end
    endgenerate

    // Assemble the descriptor from the opcode fields.
    always_comb begin
        op.valid = pattern_ok && kind_ok;
        op.rep   = opcode[4];
        op.dec   = opcode[3];
        op.kind  = kind_t'(opcode[1:0]);
    end

endmodule

// File: rtl/blkseq_step.sv
// Module: blkseq_step
// Computes the next pointers and counter for one element, and
// whether the counter is exhausted afterwards.
// Assumes: port forms count with the upper half of BC only.
module blkseq_step
    import blkseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  kind_t                kind,
    input  logic                 dec,
    input  logic [2*DATA_W-1:0]  hl,
    input  logic [2*DATA_W-1:0]  de,
    input  logic [2*DATA_W-1:0]  bc,
    output logic [2*DATA_W-1:0]  hl_n,
    output logic [2*DATA_W-1:0]  de_n,
    output logic [2*DATA_W-1:0]  bc_n,
    output logic                 cnt_zero
);

    localparam int AW = 2 * DATA_W;

    logic [AW-1:0] delta;
    logic          port_form;

    // Plus one or minus one per element.
    assign delta     = dec ? {AW{1'b1}} : AW'(1);
    assign port_form = (kind == K_PIN) || (kind == K_POUT);

    // Pointer stepping: DE moves only for copy.
    always_comb begin
        hl_n = hl + delta;
        de_n = (kind == K_COPY) ? (de + delta) : de;
    end

    // Counter decrement and exhaustion test on the decremented value.
    always_comb begin
        if (port_form) begin
            bc_n     = {bc[AW-1:DATA_W] - DATA_W'(1), bc[DATA_W-1:0]};
            cnt_zero = (bc_n[AW-1:DATA_W] == '0);
        end else begin
            bc_n     = bc - AW'(1);
            cnt_zero = (bc_n == '0);
        end
    end

endmodule

// File: rtl/blkseq_flags.sv
// Module: blkseq_flags
// Derives the status flags and the compare match for one element.
// Assumes: DATA_W is at least 4 (half-borrow sits at the nibble edge).
module blkseq_flags
    import blkseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  kind_t              kind,
    input  logic [DATA_W-1:0]  acc,
    input  logic [DATA_W-1:0]  data,
    input  logic               zf_in,
    input  logic               cnt_zero,
    output logic               pv,
    output logic               z,
    output logic               h,
    output logic               n,
    output logic               match
);

    localparam int NIB = 4;

    // Compare hit between accumulator and the fetched byte.
    assign match = (acc == data);
    // P/V reports a counter that is still running.
    assign pv    = !cnt_zero;

    // Per-operation flag rules.
    always_comb begin
        unique case (kind)
            K_COPY: begin
                z = zf_in;
                h = 1'b0;
                n = 1'b0;
            end
            K_CMP: begin
                z = match;
                h = (acc[NIB-1:0] < data[NIB-1:0]);
                n = 1'b1;
            end
            default: begin
                z = cnt_zero;
                h = 1'b0;
                n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/blkmove_seq.sv
// Module: blkmove_seq (top)
// Runs block copy, compare and optional port transfers element by
// element over request/ready byte ports, then returns the updated
// registers and flags with a one-cycle done pulse.
// Assumes: inputs are sampled only on the accepted start; memory and
// I/O targets hold ready-sampled read data valid in the ready cycle.
module blkmove_seq
    import blkseq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter bit PORT_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [7:0]           opcode,
    input  logic [DATA_W-1:0]    acc_i,
    input  logic [2*DATA_W-1:0]  bc_i,
    input  logic [2*DATA_W-1:0]  de_i,
    input  logic [2*DATA_W-1:0]  hl_i,
    input  logic                 zf_i,
    output logic                 busy,
    output logic                 done,
    output logic [2*DATA_W-1:0]  bc_o,
    output logic [2*DATA_W-1:0]  de_o,
    output logic [2*DATA_W-1:0]  hl_o,
    output logic                 flag_pv,
    output logic                 flag_z,
    output logic                 flag_h,
    output logic                 flag_n,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [2*DATA_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_ready,
    output logic                 io_req,
    output logic                 io_we,
    output logic [2*DATA_W-1:0]  io_addr,
    output logic [DATA_W-1:0]    io_wdata,
    input  logic [DATA_W-1:0]    io_rdata,
    input  logic                 io_ready
);

    localparam int AW = 2 * DATA_W;

    seq_state_t        state_q;
    blk_op_t           dec_op;
    logic              rep_q;
    logic              dir_q;
    kind_t             kind_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] data_q;
    logic [AW-1:0]     bc_q, de_q, hl_q;
    logic [AW-1:0]     bc_n, de_n, hl_n;
    logic              zin_q;
    logic              pv_q, z_q, h_q, n_q;
    logic              done_q;
    logic              cnt_zero;
    logic              pv_n, z_n, h_n, n_n, match;
    logic              rd_ok, wr_ok, more;
    logic [DATA_W-1:0] rd_byte;

    blkseq_decode #(.PORT_EN(PORT_EN)) u_decode (
        .opcode (opcode),
        .op     (dec_op)
    );

    blkseq_step #(.DATA_W(DATA_W)) u_step (
        .kind     (kind_q),
        .dec      (dir_q),
        .hl       (hl_q),
        .de       (de_q),
        .bc       (bc_q),
        .hl_n     (hl_n),
        .de_n     (de_n),
        .bc_n     (bc_n),
        .cnt_zero (cnt_zero)
    );

    blkseq_flags #(.DATA_W(DATA_W)) u_flags (
        .kind     (kind_q),
        .acc      (acc_q),
        .data     (data_q),
        .zf_in    (zin_q),
        .cnt_zero (cnt_zero),
        .pv       (pv_n),
        .z        (z_n),
        .h        (h_n),
        .n        (n_n),
        .match    (match)
    );

    // Completion of the pending read or write on its target port.
    assign rd_ok   = (kind_q == K_PIN)  ? io_ready : mem_ready;
    assign wr_ok   = (kind_q == K_POUT) ? io_ready : mem_ready;
    assign rd_byte = (kind_q == K_PIN)  ? io_rdata : mem_rdata;
    // Loop again unless single-shot, exhausted, or compare hit.
    assign more    = rep_q && !cnt_zero && !((kind_q == K_CMP) && match);

    // Drive the access for the current state onto the proper port.
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = hl_q;
        io_req   = 1'b0;
        io_we    = 1'b0;
        unique case (state_q)
            S_RD: begin
                if (kind_q == K_PIN) io_req = 1'b1;
                else                 mem_req = 1'b1;
            end
            S_WR: begin
                unique case (kind_q)
                    K_COPY: begin
                        mem_req  = 1'b1;
                        mem_we   = 1'b1;
                        mem_addr = de_q;
                    end
                    K_PIN: begin
                        mem_req = 1'b1;
                        mem_we  = 1'b1;
                    end
                    K_POUT: begin
                        io_req = 1'b1;
                        io_we  = 1'b1;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    assign mem_wdata = data_q;
    assign io_addr   = bc_q;
    assign io_wdata  = data_q;

    // Sequencer state, working registers and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rep_q   <= 1'b0;
            dir_q   <= 1'b0;
            kind_q  <= K_COPY;
            acc_q   <= '0;
            data_q  <= '0;
            bc_q    <= '0;
            de_q    <= '0;
            hl_q    <= '0;
            zin_q   <= 1'b0;
            pv_q    <= 1'b0;
            z_q     <= 1'b0;
            h_q     <= 1'b0;
            n_q     <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start && dec_op.valid) begin
                        rep_q   <= dec_op.rep;
                        dir_q   <= dec_op.dec;
                        kind_q  <= dec_op.kind;
                        acc_q   <= acc_i;
                        bc_q    <= bc_i;
                        de_q    <= de_i;
                        hl_q    <= hl_i;
                        zin_q   <= zf_i;
                        state_q <= S_RD;
                    end
                end
                S_RD: begin
                    if (rd_ok) begin
                        data_q  <= rd_byte;
                        state_q <= (kind_q == K_CMP) ? S_UPD : S_WR;
                    end
                end
                S_WR: begin
                    if (wr_ok) state_q <= S_UPD;
                end
                S_UPD: begin
                    hl_q <= hl_n;
                    de_q <= de_n;
                    bc_q <= bc_n;
                    pv_q <= pv_n;
                    z_q  <= z_n;
                    h_q  <= h_n;
                    n_q  <= n_n;
                    if (more) begin
                        state_q <= S_RD;
                    end else begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != S_IDLE);
    assign done    = done_q;
    assign bc_o    = bc_q;
    assign de_o    = de_q;
    assign hl_o    = hl_q;
    assign flag_pv = pv_q;
    assign flag_z  = z_q;
    assign flag_h  = h_q;
    assign flag_n  = n_q;

    // R9: a stalled memory access keeps all its fields.
    a_r9_hold_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9: a stalled I/O access keeps all its fields.
    a_r9_hold_io: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_ready) |=>
            (io_req && $stable(io_addr) && $stable(io_we) && $stable(io_wdata)));

    // R1: a refused opcode leaves the engine idle.
    a_r1_refuse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !dec_op.valid) |=> !busy);

    // R4: compare never writes memory.
    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (kind_q != K_CMP));

    // R6: port forms keep the low counter half across an update.
    a_r6_keep_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_UPD && (kind_q == K_PIN || kind_q == K_POUT)) |=>
            (bc_q[DATA_W-1:0] == $past(bc_q[DATA_W-1:0])));

    // R7: a repeating copy only ends on an exhausted counter.
    a_r7_copy_ends_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rep_q && kind_q == K_COPY) |-> !flag_pv);

    // R11: done is a single-cycle pulse with the engine idle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

endmodule

// File: tb/blkmove_seq_test.sv
// Bench for blkmove_seq: directed corner runs plus seeded random runs,
// each judged against a bench model of the block loop.
module blkmove_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  acc_i = 8'h00;
    logic [15:0] bc_i = 16'h0, de_i = 16'h0, hl_i = 16'h0;
    logic        zf_i = 1'b0;
    logic        busy, done;
    logic [15:0] bc_o, de_o, hl_o;
    logic        flag_pv, flag_z, flag_h, flag_n;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic        io_req, io_we;
    logic [15:0] io_addr;
    logic [7:0]  io_wdata, io_rdata;
    logic        io_ready = 1'b0;

    logic [7:0]  mem  [0:1023];
    logic [7:0]  rmem [0:1023];
    int          out_cnt = 0;
    logic [7:0]  out_last = 8'h0;
    logic [15:0] out_addr = 16'h0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit fin = 1'b0;

    // expected results of the model
    logic [15:0] e_bc, e_de, e_hl;
    logic        e_pv, e_z, e_h, e_n;
    int          e_outs;
    logic [7:0]  e_last_out;
    logic [15:0] e_last_oaddr;

    always #5 clk = ~clk;

    blkmove_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .acc_i(acc_i), .bc_i(bc_i), .de_i(de_i), .hl_i(hl_i), .zf_i(zf_i),
        .busy(busy), .done(done), .bc_o(bc_o), .de_o(de_o), .hl_o(hl_o),
        .flag_pv(flag_pv), .flag_z(flag_z), .flag_h(flag_h), .flag_n(flag_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready)
    );

    function automatic logic [7:0] io_val(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'h3C;
    endfunction

    function automatic logic [15:0] stepv(input logic [15:0] v, input logic dn);
        return dn ? v - 16'd1 : v + 16'd1;
    endfunction

    assign mem_rdata = mem[mem_addr[9:0]];
    assign io_rdata  = io_val(io_addr);

    // target models
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_we && mem_ready) mem[mem_addr[9:0]] <= mem_wdata;
        if (io_req && io_we && io_ready) begin
            out_cnt  <= out_cnt + 1;
            out_last <= io_wdata;
            out_addr <= io_addr;
        end
    end

    // random stalls, changed away from the active edge
    always @(negedge clk) begin
        mem_ready <= ($urandom % 4) != 0;
        io_ready  <= ($urandom % 3) != 0;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bench model of the whole block loop on rmem
    task automatic model(input logic [7:0] opc, input logic [7:0] a,
                         input logic [15:0] bc, input logic [15:0] de,
                         input logic [15:0] hl, input logic zin);
        logic [7:0] b;
        logic       cz;
        e_bc = bc; e_de = de; e_hl = hl;
        e_z = zin; e_h = 1'b0; e_n = 1'b0; e_pv = 1'b0; e_outs = 0;
        e_last_out = 8'h0; e_last_oaddr = 16'h0;
        for (int it = 0; it < 70000; it++) begin
            case (opc[1:0])
                2'b00: begin
                    rmem[e_de[9:0]] = rmem[e_hl[9:0]];
                    e_hl = stepv(e_hl, opc[3]); e_de = stepv(e_de, opc[3]);
                    e_bc = e_bc - 16'd1; e_h = 1'b0; e_n = 1'b0;
                end
                2'b01: begin
                    b = rmem[e_hl[9:0]];
                    e_z = (a == b); e_h = (a[3:0] < b[3:0]); e_n = 1'b1;
                    e_hl = stepv(e_hl, opc[3]); e_bc = e_bc - 16'd1;
                end
                2'b10: begin
                    rmem[e_hl[9:0]] = io_val(e_bc);
                    e_hl = stepv(e_hl, opc[3]); e_bc[15:8] = e_bc[15:8] - 8'd1;
                    e_z = (e_bc[15:8] == 8'd0); e_h = 1'b0; e_n = 1'b1;
                end
                default: begin
                    e_last_out = rmem[e_hl[9:0]]; e_last_oaddr = e_bc; e_outs++;
                    e_hl = stepv(e_hl, opc[3]); e_bc[15:8] = e_bc[15:8] - 8'd1;
                    e_z = (e_bc[15:8] == 8'd0); e_h = 1'b0; e_n = 1'b1;
                end
            endcase
            cz = opc[1] ? (e_bc[15:8] == 8'd0) : (e_bc == 16'd0);
            e_pv = !cz;
            if (!opc[4] || cz || (opc[1:0] == 2'b01 && e_z)) break;
        end
    endtask

    // launch one run, wait for done, compare with the model
    task automatic run_op(input string tag, input logic [7:0] opc,
                          input logic [7:0] a, input logic [15:0] bc,
                          input logic [15:0] de, input logic [15:0] hl,
                          input logic zin, input bit poke);
        int    ob;
        int    bad;
        string ft;
        for (int i = 0; i < 1024; i++) rmem[i] = mem[i];
        model(opc, a, bc, de, hl, zin);
        ob = out_cnt;
        @(negedge clk);
        opcode = opc; acc_i = a; bc_i = bc; de_i = de; hl_i = hl; zf_i = zin;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11", {tag, " busy after start"}, 32'(busy), 32'd1);
        if (poke) begin
            repeat (2) @(negedge clk);
            opcode = 8'hB1; bc_i = 16'h0003; acc_i = ~a; hl_i = 16'h0000;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        ft = (opc[1:0] == 2'b00) ? "R5" : (opc[1:0] == 2'b01) ? "R4" : "R6";
        chk("R6", {tag, " bc"}, 32'(bc_o), 32'(e_bc));
        chk("R3", {tag, " de"}, 32'(de_o), 32'(e_de));
        chk("R3", {tag, " hl"}, 32'(hl_o), 32'(e_hl));
        chk("R6", {tag, " pv"}, 32'(flag_pv), 32'(e_pv));
        chk(ft, {tag, " z"}, 32'(flag_z), 32'(e_z));
        chk(ft, {tag, " h"}, 32'(flag_h), 32'(e_h));
        chk(ft, {tag, " n"}, 32'(flag_n), 32'(e_n));
        chk("R11", {tag, " idle at done"}, 32'(busy), 32'd0);
        bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== rmem[i]) bad++;
        chk("R9", {tag, " memory image mismatches"}, 32'(bad), 32'd0);
        if (opc[1:0] == 2'b11) begin
            chk("R10", {tag, " port writes"}, 32'(out_cnt - ob), 32'(e_outs));
            chk("R10", {tag, " last port byte"}, 32'(out_last), 32'(e_last_out));
            chk("R10", {tag, " last port addr"}, 32'(out_addr), 32'(e_last_oaddr));
        end
        @(negedge clk);
        chk("R11", {tag, " done single pulse"}, 32'(done), 32'd0);
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        while (cyc < 190000 && !fin) @(posedge clk);
        if (!fin) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom % 8);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "reset busy", 32'(busy), 32'd0);
        chk("R11", "reset done", 32'(done), 32'd0);
        chk("R1", "reset requests", 32'({mem_req, io_req}), 32'd0);

        // R1: refused opcodes (bit 2 set, wrong high bits)
        opcode = 8'hA4; start = 1'b1; bc_i = 16'd3;
        @(negedge clk);
        opcode = 8'h20;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R1", "refused opcode busy/req", 32'({busy, mem_req, io_req}), 32'd0);
            @(negedge clk);
        end

        // R2 R7: single copy upward
        run_op("R2 single copy", 8'hA0, 8'h00, 16'd5, 16'h0200, 16'h0100, 1'b0, 1'b0);
        // R5: copy keeps incoming Z
        run_op("R5 copy keeps Z", 8'hA0, 8'h00, 16'd2, 16'h0210, 16'h0110, 1'b1, 1'b0);
        // R3 R11: repeating copy downward with a start poked while busy
        run_op("R3 R11 copy down", 8'hB8, 8'h00, 16'd6, 16'h02F0, 16'h01F0, 1'b0, 1'b1);

        // R7: repeating compare, match on third of ten
        for (int i = 0; i < 10; i++) mem[10'h300 + i] = 8'h11;
        mem[10'h302] = 8'h5A;
        run_op("R7 cmp early stop", 8'hB1, 8'h5A, 16'd10, 16'h0, 16'h0300, 1'b0, 1'b0);
        // both stop reasons on the same element
        mem[10'h313] = 8'h5A;
        for (int i = 0; i < 3; i++) mem[10'h310 + i] = 8'h12;
        run_op("R7 match at last", 8'hB1, 8'h5A, 16'd4, 16'h0, 16'h0310, 1'b0, 1'b0);
        // R4: single compare with half-borrow, counter to zero
        mem[10'h320] = 8'h2F;
        run_op("R4 cmp half borrow", 8'hA1, 8'h31, 16'd1, 16'h0, 16'h0320, 1'b0, 1'b0);
        // R8: zero counter wraps, first byte matches
        mem[10'h330] = 8'h77;
        run_op("R8 cmp wrap", 8'hB1, 8'h77, 16'd0, 16'h0, 16'h0330, 1'b0, 1'b0);

        // R10: repeating port input upward
        run_op("R10 port in", 8'hB2, 8'h00, 16'h0577, 16'h0, 16'h0340, 1'b0, 1'b0);
        // R8 R10: repeating port output downward, B zero gives 256
        run_op("R8 port out wrap", 8'hBB, 8'h00, 16'h0042, 16'h0, 16'h0300, 1'b0, 1'b0);

        // random mix of all modes
        for (int t = 0; t < 40; t++) begin
            logic [1:0]  kd;
            logic [15:0] rb;
            kd = 2'($urandom % 4);
            rb = (kd[1]) ? {8'(1 + $urandom % 12), 8'($urandom)} : 16'(1 + $urandom % 12);
            run_op("R7 random", {3'b101, 1'($urandom), 1'($urandom), 1'b0, kd},
                   8'($urandom % 8), rb, 16'($urandom), 16'($urandom),
                   1'($urandom), 1'b0);
        end

        fin = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule